// File: doc/BRIEF.md
# Three-Channel Reloading Timer with 40-bit Up-Counter

This block is a register-mapped timer peripheral. It holds three down-counting channels (two of 16 bits, one of 32 bits) and one 40-bit up-counter that runs freely. Software reaches every register through a plain single-cycle bus: an 8-bit byte address, 32-bit write data, a write strobe and combinational read data. The three channels count on one of two clock-enable pulses chosen per channel. The up-counter counts on a third pulse. Each channel raises its own interrupt line when it counts down past zero. The up-counter never interrupts.

Each channel is set up in a fixed order. First its control word is written with the mode and clock selection. Then the start value is written. Then the run bit is set, and this copies the start value into the live count. In periodic mode the channel reloads its start value when it passes zero. In free mode it wraps to all ones. In both modes it latches its interrupt until software writes anything to that channel's acknowledge address. The up-counter is read as a low word and a high word. It is started and stopped through a bit in the high word, and stopping it also zeroes it.

The block has no data streams. All of its pins are plain control and status lines, so no valid/ready handshake applies.

Top module: `tmr_unit`

## Requirements
- R1: After reset every register reads zero and all three interrupt lines are low.
- R2: Each channel's window holds four words: start value at +0x0, live count at +0x4, control at +0x8 and acknowledge at +0xC. The windows sit at 0x00, 0x20 and 0x80. Control bit 7 is run, bit 6 selects periodic mode and bit 3 selects the faster pulse. Control reads return only those three bits, and the acknowledge address reads zero.
- R3: A running channel in periodic mode counts down by one on each selected pulse. On a pulse that finds the count at zero, it reloads the start value.
- R4: Every pass through zero, in either mode, sets that channel's interrupt (bit 0, 1 or 2 of `irq`). The interrupt stays set until it is acknowledged.
- R5: A write of any data to the acknowledge address clears that channel's interrupt on the next clock. If a pass through zero happens in the same cycle, the interrupt stays set.
- R6: A running channel with control bit 6 clear wraps from zero to all ones.
- R7: With bit 3 set a channel counts only on `tick_mid`. With bit 3 clear it counts only on `tick_slow`. The other pulse has no effect.
- R8: Setting the run bit while the channel is stopped copies the start value into the count. A start-value write while running also copies it into the count. A start-value write while stopped leaves the count alone, and a stopped channel holds its count.
- R9: Writes to a channel's live-count address are ignored.
- R10: Channels 1 and 2 keep only the low 16 bits of a start-value write and read zero above them. Channel 3 keeps all 32 bits.
- R11: The up-counter adds one on each `tick_fast` only while bit 8 of the high word (0x64) is set. Writing that bit as zero stops the counter and zeroes it. Writes to the low word (0x60) are ignored.
- R12: The low word reads counter bits 31:0. The high word reads counter bits 39:32 in bits 7:0 and the run bit in bit 8, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_slow | input | 1 | Slow count pulse for channels whose bit 3 is clear |
| tick_mid | input | 1 | Faster count pulse for channels whose bit 3 is set |
| tick_fast | input | 1 | Count pulse for the 40-bit up-counter |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 3 | Interrupt per channel, bit 0 = channel 1 |

## Verification
Writes and pulses act on the clock edge where they are presented. Read data is a combinational view of the registers, so a read reflects a write or pulse one edge later. The bench drives the bus and pulses on the falling edge, holds them through one rising edge, and samples `bus_rdata` and `irq` shortly after the next falling edge. The interrupt set and clear are both registered, so they are checked in the same half-cycle after their edge. The acknowledge-against-pass-through-zero case is driven in a single cycle, to confirm that the set wins on that edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_RELOAD  = 3;
  localparam int CTL_RUN_BIT = 7;
  localparam int CTL_PER_BIT = 6;
  localparam int CTL_SEL_BIT = 3;
  localparam int FREE_RUN_BIT = 8;

  localparam logic [3:0] OFF_START = 4'h0;
  localparam logic [3:0] OFF_COUNT = 4'h4;
  localparam logic [3:0] OFF_CTL   = 4'h8;
  localparam logic [3:0] OFF_ACK   = 4'hC;

  localparam logic [7:0] FREE_LO_ADDR = 8'h60;
  localparam logic [7:0] FREE_HI_ADDR = 8'h64;

  typedef struct packed {
    logic run;
    logic periodic;
    logic fast_sel;
  } tmr_ctl_t;

  function automatic logic [7:0] chan_base(input int idx);
    case (idx)
      0:       chan_base = 8'h00;
      1:       chan_base = 8'h20;
      default: chan_base = 8'h80;
    endcase
  endfunction
endpackage

// File: rtl/tmr_reload_ctr.sv
module tmr_reload_ctr
  import tmr_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_slow,
  input  logic              tick_mid,
  input  logic              start_wr,
  input  logic              ctl_wr,
  input  logic              ack_wr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [DATA_W-1:0] start_rd,
  output logic [DATA_W-1:0] count_rd,
  output logic [DATA_W-1:0] ctl_rd,
  output logic              irq
);
  logic [WIDTH-1:0] start_q, count_q;
  tmr_ctl_t         ctl_q;
  logic             irq_q;

  logic tick_sel, step, fire, arm;

  always_comb begin
    tick_sel = ctl_q.fast_sel ? tick_mid : tick_slow;
    step     = ctl_q.run && tick_sel;
    fire     = step && (count_q == '0);
    arm      = ctl_wr && wdata[CTL_RUN_BIT] && !ctl_q.run;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      count_q <= '0;
      ctl_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (start_wr) start_q <= wdata;
      if (ctl_wr) begin
        ctl_q.run      <= wdata[CTL_RUN_BIT];
        ctl_q.periodic <= wdata[CTL_PER_BIT];
        ctl_q.fast_sel <= wdata[CTL_SEL_BIT];
      end
      if (start_wr && ctl_q.run)  count_q <= wdata;
      else if (arm)               count_q <= start_q;
      else if (fire)              count_q <= ctl_q.periodic ? start_q : '1;
      else if (step)              count_q <= count_q - 1'b1;
      if (fire)        irq_q <= 1'b1;
      else if (ack_wr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    start_rd = '0;
    start_rd[WIDTH-1:0] = start_q;
    count_rd = '0;
    count_rd[WIDTH-1:0] = count_q;
    ctl_rd = '0;
    ctl_rd[CTL_RUN_BIT] = ctl_q.run;
    ctl_rd[CTL_PER_BIT] = ctl_q.periodic;
    ctl_rd[CTL_SEL_BIT] = ctl_q.fast_sel;
  end

  assign irq = irq_q;

  // R3: periodic pass through zero reloads the start value
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.run && ctl_q.periodic && tick_sel && count_q == '0 && !start_wr && !ctl_wr)
    |=> count_q == $past(start_q));
  // R6: free mode wraps to all ones
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.run && !ctl_q.periodic && tick_sel && count_q == '0 && !start_wr && !ctl_wr)
    |=> &count_q);
  // R4: pass through zero sets the interrupt
  p_irq_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.run && tick_sel && count_q == '0) |=> irq);
  // R5: acknowledge without a coincident pass through zero clears it
  p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !fire) |=> !irq);
  // R8: stopped channel holds its count
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.run && !ctl_wr) |=> $stable(count_q));
endmodule

// File: rtl/tmr_free_ctr.sv
module tmr_free_ctr
  import tmr_pkg::*;
#(
  parameter int WIDTH  = 40,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast,
  input  logic              hi_wr,
  input  logic              run_bit,
  output logic [DATA_W-1:0] lo_rd,
  output logic [DATA_W-1:0] hi_rd
);
  localparam int HI_W = WIDTH - DATA_W;

  logic [WIDTH-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (hi_wr) begin
      run_q <= run_bit;
      if (!run_bit) cnt_q <= '0;
    end else if (run_q && tick_fast) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    lo_rd = cnt_q[DATA_W-1:0];
    hi_rd = '0;
    hi_rd[HI_W-1:0] = cnt_q[WIDTH-1:DATA_W];
    hi_rd[FREE_RUN_BIT] = run_q;
  end

  // R11: counts up by one per pulse while running
  p_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_fast && !hi_wr) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R11: stopped counter stays put
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 32,
  parameter int FREE_W  = 40,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_slow,
  input  logic              tick_mid,
  input  logic              tick_fast,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_RELOAD-1:0] irq
);
  logic [DATA_W-1:0] start_rd [NUM_RELOAD];
  logic [DATA_W-1:0] count_rd [NUM_RELOAD];
  logic [DATA_W-1:0] ctl_rd   [NUM_RELOAD];
  logic [DATA_W-1:0] free_lo, free_hi;

  for (genvar i = 0; i < NUM_RELOAD; i++) begin : g_chan
    localparam int W = (i == NUM_RELOAD - 1) ? LONG_W : SHORT_W;
    localparam logic [7:0] BASE = chan_base(i);
    logic hit;
    assign hit = bus_we && (bus_addr[7:4] == BASE[7:4]);

    tmr_reload_ctr #(.WIDTH(W), .DATA_W(DATA_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_slow(tick_slow),
      .tick_mid (tick_mid),
      .start_wr (hit && bus_addr[3:0] == OFF_START),
      .ctl_wr   (hit && bus_addr[3:0] == OFF_CTL),
      .ack_wr   (hit && bus_addr[3:0] == OFF_ACK),
      .wdata    (bus_wdata[W-1:0]),
      .start_rd (start_rd[i]),
      .count_rd (count_rd[i]),
      .ctl_rd   (ctl_rd[i]),
      .irq      (irq[i])
    );
  end

  tmr_free_ctr #(.WIDTH(FREE_W), .DATA_W(DATA_W)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_fast(tick_fast),
    .hi_wr    (bus_we && bus_addr == FREE_HI_ADDR),
    .run_bit  (bus_wdata[FREE_RUN_BIT]),
    .lo_rd    (free_lo),
    .hi_rd    (free_hi)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == FREE_LO_ADDR) bus_rdata = free_lo;
    if (bus_addr == FREE_HI_ADDR) bus_rdata = free_hi;
    for (int i = 0; i < NUM_RELOAD; i++) begin
      if (bus_addr[7:4] == chan_base(i)[7:4]) begin
        case (bus_addr[3:0])
          OFF_START: bus_rdata = start_rd[i];
          OFF_COUNT: bus_rdata = count_rd[i];
          OFF_CTL:   bus_rdata = ctl_rd[i];
          default:   ;
        endcase
      end
    end
  end

  // R5: a write to a channel's acknowledge address never raises its interrupt
  p_ack_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_ACK && !irq[0] && !tick_mid && !tick_slow) |=> !irq[0]);
endmodule

// File: tb/tmr_unit_test.sv
module tmr_unit_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_TICK = 2'd2, K_IRQ = 2'd3;
  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  addr;  // tick: 0 slow, 1 mid, 2 fast
    logic [31:0] data;  // write data / expected value / pulse count
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 57;
  localparam vec_t VECS [NV] = '{
    '{K_RD,   8'h00, 32'h0,        8'd1},   // R1
    '{K_RD,   8'h64, 32'h0,        8'd1},   // R1
    '{K_IRQ,  8'h00, 32'h0,        8'd1},   // R1
    '{K_WR,   8'h08, 32'h48,       8'd2},   // R2
    '{K_RD,   8'h08, 32'h48,       8'd2},   // R2
    '{K_WR,   8'h00, 32'h00010003, 8'd10},  // R10
    '{K_RD,   8'h00, 32'h3,        8'd10},  // R10
    '{K_RD,   8'h04, 32'h0,        8'd8},   // R8
    '{K_WR,   8'h08, 32'hC8,       8'd8},   // R8
    '{K_RD,   8'h04, 32'h3,        8'd8},   // R8
    '{K_TICK, 8'h01, 32'd3,        8'd3},   // R3
    '{K_RD,   8'h04, 32'h0,        8'd3},   // R3
    '{K_IRQ,  8'h00, 32'h0,        8'd4},   // R4
    '{K_TICK, 8'h00, 32'd2,        8'd7},   // R7
    '{K_RD,   8'h04, 32'h0,        8'd7},   // R7
    '{K_TICK, 8'h01, 32'd1,        8'd3},   // R3
    '{K_RD,   8'h04, 32'h3,        8'd3},   // R3
    '{K_IRQ,  8'h00, 32'h1,        8'd4},   // R4
    '{K_WR,   8'h0C, 32'hDEAD,     8'd5},   // R5
    '{K_IRQ,  8'h00, 32'h0,        8'd5},   // R5
    '{K_WR,   8'h04, 32'h77,       8'd9},   // R9
    '{K_RD,   8'h04, 32'h3,        8'd9},   // R9
    '{K_WR,   8'h00, 32'h10,       8'd8},   // R8
    '{K_RD,   8'h04, 32'h10,       8'd8},   // R8
    '{K_WR,   8'h08, 32'h48,       8'd8},   // R8
    '{K_WR,   8'h28, 32'h0,        8'd6},   // R6
    '{K_WR,   8'h20, 32'h1,        8'd6},   // R6
    '{K_WR,   8'h28, 32'h80,       8'd6},   // R6
    '{K_TICK, 8'h00, 32'd2,        8'd6},   // R6
    '{K_RD,   8'h24, 32'hFFFF,     8'd6},   // R6
    '{K_IRQ,  8'h00, 32'h2,        8'd4},   // R4
    '{K_TICK, 8'h01, 32'd1,        8'd7},   // R7
    '{K_RD,   8'h24, 32'hFFFF,     8'd7},   // R7
    '{K_RD,   8'h04, 32'h10,       8'd8},   // R8
    '{K_WR,   8'h88, 32'h48,       8'd10},  // R10
    '{K_WR,   8'h80, 32'hFFFFFFFF, 8'd10},  // R10
    '{K_WR,   8'h88, 32'hC8,       8'd10},  // R10
    '{K_TICK, 8'h01, 32'd1,        8'd10},  // R10
    '{K_RD,   8'h84, 32'hFFFFFFFE, 8'd10},  // R10
    '{K_RD,   8'h8C, 32'h0,        8'd2},   // R2
    '{K_WR,   8'h28, 32'hFFFFFFFF, 8'd2},   // R2
    '{K_RD,   8'h28, 32'hC8,       8'd2},   // R2
    '{K_WR,   8'h28, 32'h0,        8'd2},   // R2
    '{K_RD,   8'h64, 32'h0,        8'd12},  // R12
    '{K_TICK, 8'h02, 32'd2,        8'd11},  // R11
    '{K_RD,   8'h60, 32'h0,        8'd11},  // R11
    '{K_WR,   8'h64, 32'h100,      8'd11},  // R11
    '{K_RD,   8'h64, 32'h100,      8'd12},  // R12
    '{K_TICK, 8'h02, 32'd5,        8'd11},  // R11
    '{K_RD,   8'h60, 32'h5,        8'd11},  // R11
    '{K_WR,   8'h60, 32'h1234,     8'd11},  // R11
    '{K_RD,   8'h60, 32'h5,        8'd11},  // R11
    '{K_WR,   8'h64, 32'h0,        8'd11},  // R11
    '{K_RD,   8'h60, 32'h0,        8'd11},  // R11
    '{K_IRQ,  8'h00, 32'h2,        8'd4},   // R4
    '{K_WR,   8'h2C, 32'h0,        8'd5},   // R5
    '{K_IRQ,  8'h00, 32'h0,        8'd5}    // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_slow = 1'b0, tick_mid = 1'b0, tick_fast = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmr_unit uut (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_mid(tick_mid),
    .tick_fast(tick_fast), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [1:0] which, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_slow = (which == 2'd0);
      tick_mid  = (which == 2'd1);
      tick_fast = (which == 2'd2);
      @(negedge clk);
      tick_slow = 1'b0; tick_mid = 1'b0; tick_fast = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VECS[v].req, v);
      case (VECS[v].kind)
        K_WR:   wr(VECS[v].addr, VECS[v].data);
        K_RD:   rd_chk(tag, VECS[v].addr, VECS[v].data);
        K_TICK: pulse(VECS[v].addr[1:0], int'(VECS[v].data));
        default: begin
          @(negedge clk); #1;
          chk(tag, {29'b0, irq}, VECS[v].data);
        end
      endcase
    end

    // R5: acknowledge in the same cycle as a pass through zero, the set wins
    wr(8'h00, 32'h0);
    wr(8'h08, 32'hC8);
    rd_chk("R8 arm with zero start", 8'h04, 32'h0);
    @(negedge clk);
    bus_addr = 8'h0C; bus_wdata = 32'h5; bus_we = 1'b1; tick_mid = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_mid = 1'b0;
    #1;
    chk("R5 ack vs underflow", {29'b0, irq}, 32'h1);
    wr(8'h0C, 32'h0);
    #1;
    chk("R5 ack after", {29'b0, irq}, 32'h0);

    // R1: reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irq after reset", {29'b0, irq}, 32'h0);
    rd_chk("R1 ch3 ctl after reset", 8'h88, 32'h0);
    rd_chk("R1 ch3 count after reset", 8'h84, 32'h0);
    rd_chk("R1 ch1 start after reset", 8'h00, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule